// File: doc/BRIEF.md
# Serial Result Shift-Out Port

This block presents the most recent converter result on one serial data pin, driven by a serial clock that comes from outside the chip. The data pin also carries status. With the select line low, the pin reads low while a conversion is running. It goes high as soon as the result is ready. Falling edges of the serial clock then move the result out, most significant bit first. When all ten bits have gone out, further edges give zeros. Each time the select line falls after a conversion has finished, the stored result is loaded again, so the same value can be read as many times as needed.

The select and serial clock pins are asynchronous to the system clock. Each goes through a two-flop synchroniser with edge detection. The system clock must run at least four times faster than the serial clock. The converter engine sits next to this block. It drives a level that is high for the whole conversion and provides the result on a parallel bus, which must be valid in the cycle the level falls. The pin has tri-state behaviour: one output carries the data value and a second output carries the drive enable.

Top module: `serial_result_port`

## Requirements
- R1: `sdo_oe` is 0 while `cs_n` is high and 1 while `cs_n` is low. It follows the pin two system-clock cycles later, because of the synchroniser.
- R2: Once `conv_active` has been high for more than one cycle, `sdo_data` is 0. Serial clock edges during a conversion do not shift anything out.
- R3: In the cycle after `conv_active` falls, `sdo_data` is 1. This is the done marker. It stays 1 until the first serial clock falling edge.
- R4: Falling edges of `sclk` while `cs_n` is low put the result bits on `sdo_data` in order: result[9] after the first edge, down to result[0] after the tenth edge.
- R5: From the eleventh falling edge after a load, `sdo_data` is 0, however many more edges arrive.
- R6: A falling edge of `cs_n` after at least one finished conversion reloads the marker and the stored result. A new read gives the marker first and then the same ten bits again.
- R7: Before any conversion has finished since reset, a falling edge of `cs_n` loads nothing and `sdo_data` stays 0.
- R8: After reset, `sdo_oe` is 0 and `sdo_data` is 0.
- R9: The result is captured in the cycle `conv_active` falls. Later changes on `result_in` do not affect what a reload sends out.
- R10: Rising edges of `sclk` do not change `sdo_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous; data moves on its falling edge |
| conv_active | input | 1 | High while the converter is busy; synchronous to clk |
| result_in | input | DATA_W (10) | Converter result, valid in the cycle conv_active falls |
| sdo_oe | output | 1 | Drive enable of the serial pin (0 = high impedance) |
| sdo_data | output | 1 | Value on the serial pin when it is driven |

## Verification
On every cycle, the assertions check four things. The pin enable tracks the synchronised select line. The data line is low during a running conversion. The done marker appears right after a conversion ends. Once a frame has been fully shifted out, nothing but zeros follows until the next load. They also check that the stored result changes only at the end of a conversion. Only the bench scenarios can show the exact bit order for each result value. They also show that a reload returns the earlier result after the parallel input has changed, that select edges before the first conversion load nothing, and that clock edges during a conversion or with the select line high are ignored.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int RESULT_BITS = 10;
    localparam int SYNC_DEPTH  = 2;

    // what the frame register does this cycle
    typedef enum logic [1:0] {
        FR_HOLD  = 2'd0,
        FR_CLEAR = 2'd1,
        FR_LOAD  = 2'd2,
        FR_SHIFT = 2'd3
    } frame_act_e;

    typedef struct packed {
        frame_act_e act;
        logic       capture;   // take result_in into the store
        logic       use_new;   // load from result_in instead of the store
    } frame_cmd_t;

endpackage

// File: rtl/srp_edge_sync.sv
module srp_edge_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fell
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {CHAIN_W{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pin};
        end
    end

    assign level = chain_q[STAGES-1];
    assign fell  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_active,
    input  logic       cs_level,
    input  logic       cs_fell,
    input  logic       sclk_fell,
    output frame_cmd_t cmd
);
    logic conv_q;
    logic have_result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q        <= 1'b0;
            have_result_q <= 1'b0;
        end else begin
            conv_q <= conv_active;
            if (conv_q && !conv_active) begin
                have_result_q <= 1'b1;
            end
        end
    end

    always_comb begin
        cmd.act     = FR_HOLD;
        cmd.capture = 1'b0;
        cmd.use_new = 1'b0;
        if (conv_active) begin
            cmd.act = FR_CLEAR;
        end else if (conv_q) begin
            cmd.act     = FR_LOAD;
            cmd.capture = 1'b1;
            cmd.use_new = 1'b1;
        end else if (cs_fell && have_result_q) begin
            cmd.act = FR_LOAD;
        end else if (sclk_fell && !cs_level) begin
            cmd.act = FR_SHIFT;
        end
    end

endmodule

// File: rtl/srp_frame.sv
module srp_frame
    import srp_pkg::*;
#(
    parameter int DATA_W = RESULT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_cmd_t        cmd,
    input  logic [DATA_W-1:0] result_in,
    output logic [DATA_W-1:0] stored,
    output logic              head
);
    localparam int FRAME_W = DATA_W + 1;

    logic [FRAME_W-1:0] frame_q;
    logic [DATA_W-1:0]  store_q;
    logic [DATA_W-1:0]  load_src;

    assign load_src = cmd.use_new ? result_in : store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (cmd.capture) begin
            store_q <= result_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else begin
            case (cmd.act)
                FR_CLEAR: frame_q <= '0;
                FR_LOAD:  frame_q <= {1'b1, load_src};
                FR_SHIFT: frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                default:  frame_q <= frame_q;
            endcase
        end
    end

    assign stored = store_q;
    assign head   = frame_q[FRAME_W-1];

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int DATA_W = RESULT_BITS,
    parameter int SYNC_N = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              conv_active,
    input  logic [DATA_W-1:0] result_in,
    output logic              sdo_oe,
    output logic              sdo_data
);
    logic        cs_level;
    logic        cs_fell;
    logic        sclk_level;
    logic        sclk_fell;
    frame_cmd_t  cmd;
    logic [DATA_W-1:0] stored_q;
    logic        load_evt;
    logic        shift_evt;
    logic        capture_evt;

    srp_edge_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_cs_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (cs_n),
        .level (cs_level),
        .fell  (cs_fell)
    );

    srp_edge_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b0)) u_sclk_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (sclk),
        .level (sclk_level),
        .fell  (sclk_fell)
    );

    srp_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .conv_active (conv_active),
        .cs_level    (cs_level),
        .cs_fell     (cs_fell),
        .sclk_fell   (sclk_fell),
        .cmd         (cmd)
    );

    srp_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .result_in (result_in),
        .stored    (stored_q),
        .head      (sdo_data)
    );

    assign sdo_oe      = ~cs_level;
    assign load_evt    = (cmd.act == FR_LOAD) || (cmd.act == FR_CLEAR);
    assign shift_evt   = (cmd.act == FR_SHIFT);
    assign capture_evt = cmd.capture;

    logic unused_sclk_level;
    assign unused_sclk_level = sclk_level;

endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              conv_active,
    input logic              sdo_oe,
    input logic              sdo_data,
    input logic              load_pulse,
    input logic              shift_pulse,
    input logic              end_pulse,
    input logic [DATA_W-1:0] stored
);
    localparam int CNT_W = $clog2(DATA_W + 3);
    localparam logic [CNT_W-1:0] DRAINED = CNT_W'(DATA_W + 1);

    logic [CNT_W-1:0] shifts_q;

    always_ff @(posedge clk) begin
        if (rst || load_pulse) begin
            shifts_q <= '0;
        end else if (shift_pulse && shifts_q != DRAINED) begin
            shifts_q <= shifts_q + 1'b1;
        end
    end

    AST_OE_TRACKS_SELECT: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !$past(cs_n, 2)); // R1

    AST_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
        (conv_active && $past(conv_active)) |-> !sdo_data); // R2

    AST_DONE_MARKER: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_active) |=> sdo_data); // R3

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (shifts_q == DRAINED) |-> !sdo_data); // R5

    AST_STORE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(stored) |-> $past(end_pulse)); // R9

endmodule

bind serial_result_port srp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .conv_active (conv_active),
    .sdo_oe      (sdo_oe),
    .sdo_data    (sdo_data),
    .load_pulse  (load_evt),
    .shift_pulse (shift_evt),
    .end_pulse   (capture_evt),
    .stored      (stored_q)
);

// File: tb/test_serial_result_port.sv
`timescale 1ns/1ps
module test_serial_result_port;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         conv_active = 1'b0;
    logic [W-1:0] result_in = '0;
    logic         sdo_oe;
    logic         sdo_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    serial_result_port i_serial_result_port (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .conv_active (conv_active),
        .result_in   (result_in),
        .sdo_oe      (sdo_oe),
        .sdo_data    (sdo_data)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1;
        wait_n(4);
        sclk = 1'b0;
        wait_n(5);
    endtask

    task automatic convert(input logic [W-1:0] v);
        conv_active = 1'b1;
        result_in   = v;
        wait_n(6);
        check(sdo_data, 1'b0, "R2 busy low");
        conv_active = 1'b0;
        wait_n(1);
        result_in = ~v;           // R9: later input must not matter
        check(sdo_oe, 1'b1, "R1 driven");
        check(sdo_data, 1'b1, "R3 marker");
    endtask

    task automatic read_frame(input logic [W-1:0] v);
        sclk = 1'b1;
        wait_n(4);
        check(sdo_data, 1'b1, "R10 rising edge no shift");
        sclk = 1'b0;
        wait_n(5);
        check(sdo_data, v[W-1], "R4 bit 9");
        for (int k = 1; k < W; k++) begin
            sclk_pulse();
            check(sdo_data, v[W-1-k], "R4 data bit");
        end
        for (int z = 0; z < 3; z++) begin
            sclk_pulse();
            check(sdo_data, 1'b0, "R5 zero fill");
        end
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        check(sdo_oe, 1'b0, "R8 reset oe");
        check(sdo_data, 1'b0, "R8 reset data");

        // R7: select before any conversion
        cs_n = 1'b0;
        wait_n(5);
        check(sdo_oe, 1'b1, "R1 oe low select");
        check(sdo_data, 1'b0, "R7 no reload");
        sclk_pulse();
        check(sdo_data, 1'b0, "R7 still low");
        cs_n = 1'b1;
        wait_n(5);
        check(sdo_oe, 1'b0, "R1 oe high select");
        cs_n = 1'b0;
        wait_n(5);
        check(sdo_data, 1'b0, "R7 second fall");

        // R2: serial clock during a conversion is ignored
        conv_active = 1'b1;
        result_in   = 10'h2A5;
        wait_n(3);
        sclk_pulse();
        check(sdo_data, 1'b0, "R2 sclk ignored");
        conv_active = 1'b0;
        wait_n(1);
        check(sdo_data, 1'b1, "R3 marker after busy");
        read_frame(10'h2A5);

        for (int i = 0; i < 48; i++) begin
            logic [W-1:0] v;
            if (i < 10)       v = W'(1) << i;
            else if (i < 20)  v = ~(W'(1) << (i - 10));
            else if (i == 20) v = '0;
            else if (i == 21) v = '1;
            else              v = W'((i * 337 + 91) % 1024);
            convert(v);
            read_frame(v);
            // deselect, clock while deselected, reselect
            cs_n = 1'b1;
            wait_n(5);
            check(sdo_oe, 1'b0, "R1 released");
            sclk_pulse();
            check(sdo_oe, 1'b0, "R1 released after clock");
            cs_n = 1'b0;
            wait_n(5);
            check(sdo_oe, 1'b1, "R1 reselected");
            check(sdo_data, 1'b1, "R6 reload marker");
            read_frame(v);        // R6 and R9: same old value
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule